// File: doc/BRIEF.md
# Packet Buffer Pointer and Byte Window

This block lets a host reach a paged packet buffer one byte at a time. The host programs a 16-bit pointer in two byte-wide writes. It then reads or writes through a four-byte data window. Every window access resolves to a buffer page and a byte offset inside that page. The page is either the entry at the head of the receive queue or the page held in the packet-number register. A pointer bit chooses between the two.

The pointer has two modes. With auto-increment on, each window access uses the current offset and then steps the offset by one. The step wraps inside the offset field, so streaming loops need no pointer rewrite. With auto-increment off, the pointer stays fixed and the low two bits of the window select pick one of four neighbouring bytes. The buffer itself sits outside the block. The block drives its address, write data and strobes, and it returns the buffer's read byte to the host in the same cycle.

Top module: `pkt_ram_window`

## Requirements
- R1: After reset the pointer is zero, so reads of selects 0 and 1 return 0x00.
- R2: Select 0 writes and reads pointer bits [7:0], and select 1 writes pointer bits [15:8]. Each write changes only its own byte.
- R3: A read of select 1 returns pointer bits [15:8] with bit 3 forced to zero (mask 0xF7).
- R4: Pointer bit 15 chooses the page. When it is 1, the page is `rx_head_i`. When it is 0, the page is `pkt_num_i`.
- R5: The buffer address is {page[1:0], byte offset[10:0]}, with the byte offset taken from pointer bits [10:0].
- R6: With pointer bit 14 set, a window access uses offset bits [10:0] unchanged. Afterwards bits [10:0] increase by one, wrapping from 0x7FF to 0x000, and bits [15:11] keep their value.
- R7: With pointer bit 14 clear, a window access uses offset bits [10:0] plus select bits [1:0], taken modulo 2048, and the pointer is not modified.
- R8: When the selected page is 4 or above, a window access is dropped. No write strobe is raised, a read returns 0x00, and the pointer does not advance.
- R9: A window write raises `ram_we_o` for exactly that cycle, with `ram_wdata_o` equal to the host byte.
- R10: Window accesses in consecutive cycles with auto-increment on reach consecutive bytes, because the pointer advances in the cycle of the access.
- R11: Selects 2 and 3 are reserved. Writes to them change nothing, and reads of them return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_rd_i | input | 1 | Host byte read strobe |
| host_wr_i | input | 1 | Host byte write strobe |
| host_sel_i | input | 3 | Register select: 0 pointer low, 1 pointer high, 2-3 reserved, 4-7 data window byte 0-3 |
| host_wdata_i | input | 8 | Host write byte |
| host_rdata_o | output | 8 | Host read byte |
| rx_head_i | input | 8 | Page number at the head of the receive queue |
| pkt_num_i | input | 8 | Page number from the packet-number register |
| ram_addr_o | output | 13 | Buffer byte address |
| ram_wdata_o | output | 8 | Buffer write byte |
| ram_we_o | output | 1 | Buffer write enable |
| ram_re_o | output | 1 | Buffer read strobe |
| ram_rdata_i | input | 8 | Buffer read byte, valid in the same cycle as the address |

## Verification
The assertions assume that the host never raises the read and write strobes in the same cycle. They also assume that the buffer returns read data combinationally from the address the block drives. The bench drives exactly one strobe per access, always on the falling edge. It models the buffer as an asynchronous-read array, so a read byte and the pointer advance it triggers line up in one cycle. The page inputs are changed only while no strobe is active.

// File: rtl/pkt_win_pkg.sv
package pkt_win_pkg;
  localparam int PTR_W        = 16;
  localparam int BYTE_W       = 8;
  localparam int RX_SEL_BIT   = 15;
  localparam int AUTO_INC_BIT = 14;
  localparam logic [BYTE_W-1:0] HI_RD_MASK = 8'hF7;

  typedef enum logic [2:0] {
    SEL_PTR_LO = 3'd0,
    SEL_PTR_HI = 3'd1,
    SEL_RSV_A  = 3'd2,
    SEL_RSV_B  = 3'd3,
    SEL_WIN_0  = 3'd4,
    SEL_WIN_1  = 3'd5,
    SEL_WIN_2  = 3'd6,
    SEL_WIN_3  = 3'd7
  } host_sel_e;
endpackage

// File: rtl/pkt_win_ptr.sv
module pkt_win_ptr
  import pkt_win_pkg::*;
#(
  parameter int OFFS_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              adv_i,
  output logic [PTR_W-1:0]  ptr_o
);
  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (wr_lo_i) begin
      ptr_q[BYTE_W-1:0] <= wdata_i;
    end else if (wr_hi_i) begin
      ptr_q[PTR_W-1:BYTE_W] <= wdata_i;
    end else if (adv_i) begin
      // step wraps inside the offset field only
      ptr_q[OFFS_W-1:0] <= ptr_q[OFFS_W-1:0] + 1'b1;
    end
  end

  assign ptr_o = ptr_q;

  assert_adv_wraps_offset_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> (ptr_o[OFFS_W-1:0] == OFFS_W'($past(ptr_o[OFFS_W-1:0]) + 1'b1)) &&
              (ptr_o[PTR_W-1:OFFS_W] == $past(ptr_o[PTR_W-1:OFFS_W])));

  assert_ptr_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !wr_lo_i && !wr_hi_i) |=> $stable(ptr_o));

  assert_one_ptr_update_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({wr_lo_i, wr_hi_i, adv_i}) <= 1);
endmodule

// File: rtl/pkt_win_page_sel.sv
module pkt_win_page_sel #(
  parameter int PAGE_W    = 8,
  parameter int NUM_PAGES = 4,
  localparam int PG_IDX_W = $clog2(NUM_PAGES)
) (
  input  logic [PAGE_W-1:0]   rx_head_i,
  input  logic [PAGE_W-1:0]   pkt_num_i,
  input  logic                use_rx_i,
  output logic [PG_IDX_W-1:0] page_idx_o,
  output logic                page_ok_o
);
  logic [PAGE_W-1:0] page;

  assign page       = use_rx_i ? rx_head_i : pkt_num_i;
  assign page_idx_o = page[PG_IDX_W-1:0];

  generate
    if ((1 << PG_IDX_W) == NUM_PAGES) begin : g_pow2
      assign page_ok_o = (page[PAGE_W-1:PG_IDX_W] == '0);
    end else begin : g_cmp
      assign page_ok_o = (page < PAGE_W'(NUM_PAGES));
    end
  endgenerate
endmodule

// File: rtl/pkt_win_addr.sv
module pkt_win_addr #(
  parameter int OFFS_W   = 11,
  parameter int PG_IDX_W = 2,
  localparam int ADDR_W  = PG_IDX_W + OFFS_W
) (
  input  logic [OFFS_W-1:0]   offs_i,
  input  logic [1:0]          win_i,
  input  logic                auto_inc_i,
  input  logic [PG_IDX_W-1:0] page_idx_i,
  output logic [ADDR_W-1:0]   addr_o
);
  logic [OFFS_W-1:0] offs_eff;

  // fixed-pointer mode adds the window byte; auto-inc mode ignores it
  always_comb begin
    if (auto_inc_i) offs_eff = offs_i;
    else            offs_eff = offs_i + OFFS_W'(win_i);
  end

  assign addr_o = {page_idx_i, offs_eff};
endmodule

// File: rtl/pkt_ram_window.sv
module pkt_ram_window
  import pkt_win_pkg::*;
#(
  parameter int OFFS_W    = 11,
  parameter int PAGE_W    = 8,
  parameter int NUM_PAGES = 4,
  localparam int PG_IDX_W = $clog2(NUM_PAGES),
  localparam int ADDR_W   = PG_IDX_W + OFFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_rd_i,
  input  logic              host_wr_i,
  input  logic [2:0]        host_sel_i,
  input  logic [BYTE_W-1:0] host_wdata_i,
  output logic [BYTE_W-1:0] host_rdata_o,
  input  logic [PAGE_W-1:0] rx_head_i,
  input  logic [PAGE_W-1:0] pkt_num_i,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [BYTE_W-1:0] ram_wdata_o,
  output logic              ram_we_o,
  output logic              ram_re_o,
  input  logic [BYTE_W-1:0] ram_rdata_i
);
  logic [PTR_W-1:0]    ptr;
  logic [PG_IDX_W-1:0] page_idx;
  logic                page_ok;
  logic                is_win;
  logic                win_acc;
  logic                wr_lo, wr_hi, adv;

  assign is_win  = host_sel_i[2];
  assign win_acc = (host_rd_i | host_wr_i) & is_win & page_ok;
  assign wr_lo   = host_wr_i & (host_sel_i == SEL_PTR_LO);
  assign wr_hi   = host_wr_i & (host_sel_i == SEL_PTR_HI);
  assign adv     = win_acc & ptr[AUTO_INC_BIT];

  pkt_win_ptr #(.OFFS_W(OFFS_W)) u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_lo_i (wr_lo),
    .wr_hi_i (wr_hi),
    .wdata_i (host_wdata_i),
    .adv_i   (adv),
    .ptr_o   (ptr)
  );

  pkt_win_page_sel #(.PAGE_W(PAGE_W), .NUM_PAGES(NUM_PAGES)) u_page (
    .rx_head_i  (rx_head_i),
    .pkt_num_i  (pkt_num_i),
    .use_rx_i   (ptr[RX_SEL_BIT]),
    .page_idx_o (page_idx),
    .page_ok_o  (page_ok)
  );

  pkt_win_addr #(.OFFS_W(OFFS_W), .PG_IDX_W(PG_IDX_W)) u_addr (
    .offs_i     (ptr[OFFS_W-1:0]),
    .win_i      (host_sel_i[1:0]),
    .auto_inc_i (ptr[AUTO_INC_BIT]),
    .page_idx_i (page_idx),
    .addr_o     (ram_addr_o)
  );

  assign ram_wdata_o = host_wdata_i;
  assign ram_we_o    = host_wr_i & is_win & page_ok;
  assign ram_re_o    = host_rd_i & is_win & page_ok;

  always_comb begin
    unique case (host_sel_i)
      SEL_PTR_LO: host_rdata_o = ptr[BYTE_W-1:0];
      SEL_PTR_HI: host_rdata_o = ptr[PTR_W-1:BYTE_W] & HI_RD_MASK;
      SEL_WIN_0, SEL_WIN_1, SEL_WIN_2, SEL_WIN_3:
                  host_rdata_o = page_ok ? ram_rdata_i : '0;
      default:    host_rdata_o = '0;
    endcase
  end

  assert_single_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(host_rd_i && host_wr_i));

  assert_we_tracks_host_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (host_wr_i && ram_wdata_o == host_wdata_i && !ram_re_o));

  assert_bad_page_reads_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rd_i && is_win && !ram_re_o) |-> (host_rdata_o == '0));

  assert_hi_read_masked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_sel_i == SEL_PTR_HI) |-> (host_rdata_o[3] == 1'b0));
endmodule

// File: tb/pkt_ram_window_bench.sv
`timescale 1ns/1ps
module pkt_ram_window_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [2:0]  sel = '0;
  logic [7:0]  wdata = '0, rdata;
  logic [7:0]  rx_head = '0, pkt_num = '0;
  logic [12:0] ram_addr;
  logic [7:0]  ram_wdata, ram_rdata;
  logic        ram_we, ram_re;
  logic [7:0]  mem [8192];
  int          n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  pkt_ram_window u_pkt_ram_window (
    .clk_i(clk), .rst_ni(rst_n), .host_rd_i(rd), .host_wr_i(wr),
    .host_sel_i(sel), .host_wdata_i(wdata), .host_rdata_o(rdata),
    .rx_head_i(rx_head), .pkt_num_i(pkt_num), .ram_addr_o(ram_addr),
    .ram_wdata_o(ram_wdata), .ram_we_o(ram_we), .ram_re_o(ram_re),
    .ram_rdata_i(ram_rdata)
  );

  assign ram_rdata = mem[ram_addr];
  always @(posedge clk) if (ram_we) mem[ram_addr] <= ram_wdata;

  function automatic logic [7:0] pat(input int a);
    logic [12:0] x = 13'(a);
    return x[7:0] ^ {3'b0, x[12:8]} ^ 8'h5A;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); sel = s; wdata = d; wr = 1'b1;
    @(posedge clk); #1 wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] s, output logic [7:0] d);
    @(negedge clk); sel = s; rd = 1'b1;
    #1 d = rdata;
    @(posedge clk); #1 rd = 1'b0;
  endtask

  task automatic set_ptr(input logic [15:0] p);
    wr_reg(3'd0, p[7:0]);
    wr_reg(3'd1, p[15:8]);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd_reg(3'd0, v); chk("R1 ptr lo", v, 8'h00);
    rd_reg(3'd1, v); chk("R1 ptr hi", v, 8'h00);
  endtask

  task automatic t_ptr_bytes;
    logic [7:0] v;
    wr_reg(3'd0, 8'h34); wr_reg(3'd1, 8'h12);
    rd_reg(3'd0, v); chk("R2 lo", v, 8'h34);
    rd_reg(3'd1, v); chk("R2 hi", v, 8'h12);
    wr_reg(3'd1, 8'hFF);
    rd_reg(3'd1, v); chk("R3 hi masked", v, 8'hF7);
    rd_reg(3'd0, v); chk("R2 lo kept", v, 8'h34);
    wr_reg(3'd2, 8'hAA); wr_reg(3'd3, 8'hBB);
    rd_reg(3'd0, v); chk("R11 lo kept", v, 8'h34);
    rd_reg(3'd1, v); chk("R11 hi kept", v, 8'hF7);
    rd_reg(3'd2, v); chk("R11 rsv read", v, 8'h00);
  endtask

  task automatic t_autoinc;
    logic [7:0] v;
    pkt_num = 8'd2; rx_head = 8'd0;
    set_ptr(16'h47FE);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); sel = 3'(4 + i); wdata = 8'hA1 + 8'(i); wr = 1'b1;
    end
    @(posedge clk); #1 wr = 1'b0;
    chk("R10 byte 0x7FE", mem[13'h17FE], 8'hA1);
    chk("R10 byte 0x7FF", mem[13'h17FF], 8'hA2);
    chk("R6 wrap to 0", mem[13'h1000], 8'hA3);
    rd_reg(3'd0, v); chk("R6 offset after wrap", v, 8'h01);
    rd_reg(3'd1, v); chk("R6 upper bits kept", v, 8'h40);
    set_ptr(16'h47FE);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); sel = 3'd4; rd = 1'b1;
      #1 chk("R10 burst read", rdata, 8'hA1 + 8'(i));
    end
    @(posedge clk); #1 rd = 1'b0;
  endtask

  task automatic t_rxsel;
    logic [7:0] v;
    rx_head = 8'd3; pkt_num = 8'd1;
    set_ptr(16'h8010);
    wr_reg(3'd6, 8'hC5);
    chk("R4 rx page write", mem[13'h1812], 8'hC5);
    @(negedge clk); sel = 3'd6; rd = 1'b1;
    #1 chk("R5 address", ram_addr, 13'h1812);
    chk("R4 rx page read", rdata, 8'hC5);
    @(posedge clk); #1 rd = 1'b0;
    wr_reg(3'd1, 8'h00);
    rd_reg(3'd4, v); chk("R4 pnum page read", v, pat(13'h0810));
  endtask

  task automatic t_noinc;
    logic [7:0] v;
    pkt_num = 8'd0;
    set_ptr(16'h0100);
    for (int i = 0; i < 4; i++) wr_reg(3'(4 + i), 8'hD0 + 8'(i));
    for (int i = 0; i < 4; i++) chk("R7 window byte", mem[13'h0100 + i], 8'hD0 + 8'(i));
    rd_reg(3'd0, v); chk("R7 lo unchanged", v, 8'h00);
    rd_reg(3'd1, v); chk("R7 hi unchanged", v, 8'h01);
    set_ptr(16'h07FF);
    wr_reg(3'd7, 8'hE7);
    chk("R7 offset sum wraps", mem[13'h0002], 8'hE7);
    chk("R9 no stray write", mem[13'h0802], pat(13'h0802));
  endtask

  task automatic t_bad_page;
    logic [7:0] v;
    pkt_num = 8'd5; rx_head = 8'd7;
    set_ptr(16'h4020);
    @(negedge clk); sel = 3'd4; wdata = 8'h99; wr = 1'b1;
    #1 chk("R8 no write strobe", ram_we, 1'b0);
    @(posedge clk); #1 wr = 1'b0;
    chk("R8 buffer untouched", mem[13'h0820], pat(13'h0820));
    rd_reg(3'd4, v); chk("R8 read zero", v, 8'h00);
    rd_reg(3'd0, v); chk("R8 ptr not advanced", v, 8'h20);
    wr_reg(3'd1, 8'hC0);
    rd_reg(3'd5, v); chk("R8 rx page too high", v, 8'h00);
    rd_reg(3'd0, v); chk("R8 ptr still held", v, 8'h20);
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8192; i++) mem[i] = pat(i);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_ptr_bytes();
    t_autoinc();
    t_rxsel();
    t_noinc();
    t_bad_page();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule